// File: doc/BRIEF.md
# Periodic Wake-up Interrupt Timer

This block counts enable pulses from one of two tick sources and raises a sticky timeout flag each time a programmed period has elapsed. The flag drives an interrupt request line, which an enable bit can mask. Software controls the block through one 8-bit control and status register. The register sits on a simple synchronous bus with a select, a write enable, write data and registered read data. The period value arrives on its own 16-bit input port.

Both tick sources are single-cycle enable pulses in the one system clock domain. A source-select bit picks the source. That bit is frozen while the timer runs, and it is also frozen on the write that starts the timer. Software acknowledges a timeout by writing 1 to the flag bit. An acknowledge that arrives in the same cycle as a new timeout takes priority, so the flag ends up clear.

Top module: `wkup_timer`

## Requirements
- R1: After a synchronous active-low reset, every register bit is 0, the read data is 0x00 and the interrupt request is 0.
- R2: The register layout is: bit 7 is the source select, bit 2 is the run enable, bit 1 is the interrupt enable and bit 0 is the timeout flag. Bits 6 to 3 always read as 0, and writes to them are ignored.
- R3: A cycle with select high and write enable low is a read. The register value appears on the read data one clock later. A read changes no bit.
- R4: A write updates the source-select bit only if the run enable is 0 before the write and the written bit 2 is 0. Otherwise the source-select bit keeps its value.
- R5: With source select 0, only the dedicated tick input advances the timer. With source select 1, only the bus tick input does. Pulses on the unselected input have no effect.
- R6: While run enable is 0 the counter is held at 0. When it is 1, the flag is set on the (P+1)-th selected tick, where P is the period input, and the counter restarts so that timeouts repeat every P+1 ticks.
- R7: Only a write with bit 0 set clears the flag. A write with bit 0 clear leaves the flag unchanged, and clearing run enable does not clear it.
- R8: If a flag-clear write and a timeout happen in the same cycle, the flag ends up 0.
- R9: The interrupt request is 1 exactly when both the flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write enable (read when low with select) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| osc_tick | input | 1 | Dedicated tick pulse (source select 0) |
| bus_tick | input | 1 | Bus clock tick pulse (source select 1) |
| period | input | 16 | Timeout period P, P+1 ticks per timeout |
| irq | output | 1 | Interrupt request |

## Verification
A write or a tick sampled at one rising edge changes the register bits and the flag at that same edge. The interrupt request follows the flag and the enable with no further register, so it is due at that edge too. Read data is due one edge after the read strobe. The bench drives every input on the falling edge and samples outputs on the next falling edge, so each result is checked exactly one edge after its cause. Period checks count ticks, and they test both the tick before the expected timeout and the timeout tick itself.

// File: rtl/wkup_pkg.sv
// Package: shared widths, bit positions and the control-field type for the
// periodic wake-up timer. Assumes an 8-bit register image.
package wkup_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned SRC_BIT = 7;
    localparam int unsigned RUN_BIT = 2;
    localparam int unsigned IEN_BIT = 1;
    localparam int unsigned FLG_BIT = 0;

    localparam logic [REG_W-1:0] SRC_MASK = REG_W'(1) << SRC_BIT;
    localparam logic [REG_W-1:0] RUN_MASK = REG_W'(1) << RUN_BIT;
    localparam logic [REG_W-1:0] IEN_MASK = REG_W'(1) << IEN_BIT;
    localparam logic [REG_W-1:0] FLG_MASK = REG_W'(1) << FLG_BIT;
    localparam logic [REG_W-1:0] IMP_MASK = SRC_MASK | RUN_MASK | IEN_MASK | FLG_MASK;
    localparam logic [REG_W-1:0] RSV_MASK = ~IMP_MASK;

    typedef struct packed {
        logic src;   // tick source select
        logic run;   // timer running
        logic ien;   // interrupt enable
        logic flg;   // sticky timeout flag
    } ctrl_t;
endpackage

// File: rtl/wkup_tick_sel.sv
// Tick source multiplexer: forwards the pulse of the selected source.
// Assumes both inputs are single-cycle enables in the system clock domain.
module wkup_tick_sel (
    input  logic src_i,
    input  logic osc_tick_i,
    input  logic bus_tick_i,
    output logic tick_o
);
    // Pick the bus tick when select is 1, else the dedicated tick.
    always_comb begin
        tick_o = src_i ? bus_tick_i : osc_tick_i;
    end
endmodule

// File: rtl/wkup_counter.sv
// Period counter: counts selected ticks from 0 while running. On a tick
// with the count equal to the period it pulses timeout and reloads to 0.
// Assumes the period may change at any time; the compare uses its live value.
module wkup_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             timeout_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    // Detect the tick that completes the period.
    always_comb begin
        at_end    = (cnt_q == period_i);
        timeout_o = run_i & tick_i & at_end;
    end

    // Hold at zero when stopped, advance or reload on a tick when running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0)); // R6
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (cnt_q == '0)); // R6
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/wkup_ctrl_reg.sv
// Control/status register: holds source select, run enable, interrupt
// enable and the sticky flag, and serves registered reads. Assumes one
// select strobe per access; a strobe with write low is a read.
module wkup_ctrl_reg
    import wkup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             timeout_i,
    output ctrl_t            ctrl_o,
    output logic [REG_W-1:0] rdata_o
);
    ctrl_t            ctrl_q;
    logic             wr_hit;
    logic             rd_hit;
    logic             wd_src;
    logic             wd_run;
    logic             wd_ien;
    logic             wd_clr;
    logic             src_ok;
    logic [REG_W-1:0] image;

    // Decode the access and the written fields.
    always_comb begin
        wr_hit = sel_i & wr_i;
        rd_hit = sel_i & ~wr_i;
        wd_src = |(wdata_i & SRC_MASK);
        wd_run = |(wdata_i & RUN_MASK);
        wd_ien = |(wdata_i & IEN_MASK);
        wd_clr = wr_hit & |(wdata_i & FLG_MASK);
        src_ok = wr_hit & ~ctrl_q.run & ~wd_run;
    end

    // Source select: writable only while stopped and not being started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.src <= 1'b0;
        end else if (src_ok) begin
            ctrl_q.src <= wd_src;
        end
    end

    // Run and interrupt enables: plain write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.run <= 1'b0;
            ctrl_q.ien <= 1'b0;
        end else if (wr_hit) begin
            ctrl_q.run <= wd_run;
            ctrl_q.ien <= wd_ien;
        end
    end

    // Flag: a clear write takes priority over a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.flg <= 1'b0;
        end else if (wd_clr) begin
            ctrl_q.flg <= 1'b0;
        end else if (timeout_i) begin
            ctrl_q.flg <= 1'b1;
        end
    end

    // Assemble the read image; reserved bits stay zero.
    always_comb begin
        image          = '0;
        image[SRC_BIT] = ctrl_q.src;
        image[RUN_BIT] = ctrl_q.run;
        image[IEN_BIT] = ctrl_q.ien;
        image[FLG_BIT] = ctrl_q.flg;
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_hit) begin
            rdata_o <= image;
        end
    end

    assign ctrl_o = ctrl_q;

    AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.run |=> $stable(ctrl_q.src)); // R4
    AST_SRC_LOCK_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wd_run) |=> $stable(ctrl_q.src)); // R4
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wd_clr |=> !ctrl_q.flg); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.flg && !wd_clr) |=> ctrl_q.flg); // R7
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && !wd_clr) |=> ctrl_q.flg); // R6
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !timeout_i) |=> $stable(ctrl_q)); // R3
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & RSV_MASK) == '0); // R2
endmodule

// File: rtl/wkup_timer.sv
// Periodic wake-up interrupt timer top: register, tick selection, period
// counter and interrupt output. Assumes all inputs are synchronous to clk.
module wkup_timer
    import wkup_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             osc_tick,
    input  logic             bus_tick,
    input  logic [CNT_W-1:0] period,
    output logic             irq
);
    ctrl_t ctrl;
    logic  tick;
    logic  timeout;

    wkup_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (reg_sel),
        .wr_i      (reg_wr),
        .wdata_i   (reg_wdata),
        .timeout_i (timeout),
        .ctrl_o    (ctrl),
        .rdata_o   (reg_rdata)
    );

    wkup_tick_sel u_sel (
        .src_i      (ctrl.src),
        .osc_tick_i (osc_tick),
        .bus_tick_i (bus_tick),
        .tick_o     (tick)
    );

    wkup_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run),
        .tick_i    (tick),
        .period_i  (period),
        .timeout_o (timeout)
    );

    // Request an interrupt while the flag is set and enabled.
    always_comb begin
        irq = ctrl.flg & ctrl.ien;
    end

    AST_IRQ_FOLLOWS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && ctrl.ien && !(reg_sel && reg_wr)) |=> irq); // R9
endmodule

// File: tb/wkup_timer_tb.sv
module wkup_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        osc_tick = 1'b0;
    logic        bus_tick = 1'b0;
    logic [15:0] period = 16'd3;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    wkup_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .osc_tick(osc_tick),
        .bus_tick(bus_tick), .period(period), .irq(irq)
    );

    // {write data, expected read-back} walked with no ticks
    localparam logic [15:0] VEC [8] = '{
        16'h80_80, 16'h86_86, 16'h04_84, 16'h00_80,
        16'h04_84, 16'h00_80, 16'h7A_02, 16'h01_00
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        reg_sel = 1'b1; reg_wr = 1'b0;
        @(negedge clk);
        reg_sel = 1'b0;
        v = reg_rdata;
    endtask

    task automatic ticks(int n, logic use_bus);
        for (int i = 0; i < n; i++) begin
            osc_tick = !use_bus; bus_tick = use_bus;
            @(negedge clk);
            osc_tick = 1'b0; bus_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 rdata", reg_rdata, 8'h00);
        rd(v); chk("R1 reg", v, 8'h00);

        // R2/R4 register semantics table
        foreach (VEC[i]) begin
            wr(VEC[i][15:8]);
            rd(v);
            chk("R2 R4 table", v, VEC[i][7:0]);
        end

        // R5 R6 period 3 on dedicated tick, bus ticks ignored
        period = 16'd3;
        wr(8'h06);
        ticks(3, 1'b0);
        ticks(5, 1'b1);
        chk("R5 bus ignored", {7'd0, irq}, 8'h00);
        rd(v); chk("R6 before period", v, 8'h06);
        ticks(1, 1'b0);
        chk("R6 R9 timeout irq", {7'd0, irq}, 8'h01);
        // R3 read has no side effect
        rd(v); chk("R3 read1", v, 8'h07);
        rd(v); chk("R3 read2", v, 8'h07);
        // R7 write 0 to flag keeps it
        wr(8'h06);
        rd(v); chk("R7 zero write", v, 8'h07);
        // R7 clear then repeat period
        wr(8'h07);
        chk("R7 cleared irq", {7'd0, irq}, 8'h00);
        ticks(3, 1'b0);
        chk("R6 repeat early", {7'd0, irq}, 8'h00);
        ticks(1, 1'b0);
        chk("R6 repeat", {7'd0, irq}, 8'h01);
        // R9 masked
        wr(8'h04);
        chk("R9 masked irq", {7'd0, irq}, 8'h00);
        rd(v); chk("R9 masked flag", v, 8'h05);
        // R7 disabling keeps flag
        wr(8'h02);
        rd(v); chk("R7 disable keeps", v, 8'h03);
        chk("R9 irq on stopped", {7'd0, irq}, 8'h01);
        // R6 counter reset by stop
        wr(8'h07);
        ticks(2, 1'b0);
        wr(8'h02);
        ticks(2, 1'b0);
        wr(8'h06);
        ticks(3, 1'b0);
        chk("R6 restart from 0", {7'd0, irq}, 8'h00);
        ticks(1, 1'b0);
        chk("R6 restart timeout", {7'd0, irq}, 8'h01);

        // R8 clear wins over coincident timeout (period 0)
        period = 16'd0;
        wr(8'h07);
        ticks(1, 1'b0);
        chk("R6 period0", {7'd0, irq}, 8'h01);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h07; osc_tick = 1'b1;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; osc_tick = 1'b0;
        chk("R8 clear wins irq", {7'd0, irq}, 8'h00);
        rd(v); chk("R8 clear wins reg", v, 8'h06);

        // R5 bus tick source, R4 lock while running
        period = 16'd1;
        wr(8'h02);
        wr(8'h82);
        wr(8'h86);
        ticks(4, 1'b0);
        chk("R5 osc ignored", {7'd0, irq}, 8'h00);
        ticks(1, 1'b1);
        chk("R5 bus early", {7'd0, irq}, 8'h00);
        ticks(1, 1'b1);
        chk("R5 bus timeout", {7'd0, irq}, 8'h01);
        wr(8'h06);
        rd(v); chk("R4 locked running", v, 8'h87);

        // R2 reserved bits ignored on a running write
        wr(8'hFF);
        rd(v); chk("R2 reserved", v, 8'h86);
        finish_run();
    end
endmodule